// File: doc/BRIEF.md
# Gated Clock Divider Slice

This block derives one peripheral clock from one of two source clocks. It has three stages in a row, and elaboration parameters select the form of each. The first stage is a source selector that can be left out. It chooses between a base oscillator and a PLL output without glitches. The second stage is a programmable period counter, or a plain pass-through when no divider is built. The third stage is an enable gate that can also be left out.

The divide ratio comes from a field of configurable width, and a mode parameter fixes how that field is decoded. The first decoding is field plus one. The second is twice field plus one. The third is two shifted left by the field. The slice reports the field value it is currently using on a registered readback port. Software can therefore tell when a requested ratio has actually been applied.

Top module: `clk_slice`

## Requirements
- R1: With the field-plus-one decoding, a field value F gives an output period of (F+1) source periods.
- R2: With the doubled decoding, a field value F gives an output period of 2·(F+1) source periods, with high and low phases equal.
- R3: With the shift decoding, a field value F gives an output period of (2<<F) source periods, with high and low phases equal.
- R4: When built without a divider, the slice passes the selected source through unchanged, ignores the field, and reads back a rate code of 0.
- R5: An odd ratio R holds the output high for (R+1)/2 source periods and low for (R-1)/2. A ratio of 1 passes the source through unchanged.
- R6: With the gate built, enable 1 runs the output and enable 0 holds it low with no edges. After re-enable, the first high pulse has full width. A slice built without the gate keeps running regardless of the enable.
- R7: Select 0 routes the base oscillator and select 1 routes the PLL source. At most one source is enabled into the divider at any time.
- R8: A new field value is picked up only at the end of the output period in progress. The rate code port returns the field value in use and changes at that same boundary.
- R9: While reset is held, the output is low and the rate code is 0 in every configuration the bench builds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base oscillator source |
| clk_pll_i | input | 1 | PLL source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_en_i | input | 1 | Output enable (1 = run) |
| src_sel_i | input | 1 | Source select (0 = base, 1 = PLL) |
| div_field_i | input | DIV_W | Divide field, decoded per DIV_MODE |
| clk_o | output | 1 | Derived clock |
| rate_code_o | output | DIV_W | Field value currently applied by the divider |

## Verification
The bench builds four slices side by side and measures each one's high time and period in nanoseconds against values computed from the requirements. The first slice uses the field-plus-one decoding with a 4-bit field, a gate and a selector. It covers odd ratios, the ratio-1 pass-through and source switching. The second uses the doubled decoding with an 8-bit field, which allows the readback timing check at a period boundary. The third uses the shift decoding with a 3-bit field and a selector but no gate, which shows that an ungated slice keeps running. The fourth has no divider and a 16-bit field, which shows that the field is ignored.

// File: rtl/clk_slice_pkg.sv
`timescale 1ns/1ps
package clk_slice_pkg;

  // Divide-field decoding chosen at elaboration.
  typedef enum logic [1:0] {
    DIV_NONE_E  = 2'd0,  // no divider, source passes through
    DIV_INC_E   = 2'd1,  // ratio = field + 1
    DIV_DBL_E   = 2'd2,  // ratio = 2 * (field + 1)
    DIV_SHIFT_E = 2'd3   // ratio = 2 << field
  } div_mode_e;

  // Width of the period counter needed to hold the largest ratio.
  function automatic int cnt_width(div_mode_e m, int w);
    case (m)
      DIV_NONE_E: return 1;
      DIV_INC_E:  return w + 1;
      DIV_DBL_E:  return w + 2;
      default:    return (w >= 5) ? 31 : (1 << w) + 1;
    endcase
  endfunction

endpackage

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
// Glitch-free two-source selector. Each source enables itself through a
// two-stage chain clocked on its own falling edge, and only after the
// other source's enable has dropped.
module clk_src_sel #(
  parameter bit HAS_MUX = 1'b1
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic clk_o,
  output logic a_en_o,
  output logic b_en_o
);

  if (HAS_MUX) begin : g_sel
    logic a_s1, a_en, b_s1, b_en;

    always_ff @(negedge clk_a_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_s1 <= 1'b0;
        a_en <= 1'b0;
      end else begin
        a_s1 <= ~sel_i & ~b_en;
        a_en <= a_s1;
      end
    end

    always_ff @(negedge clk_b_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_s1 <= 1'b0;
        b_en <= 1'b0;
      end else begin
        b_s1 <= sel_i & ~a_en;
        b_en <= b_s1;
      end
    end

    assign clk_o  = (clk_a_i & a_en) | (clk_b_i & b_en);
    assign a_en_o = a_en;
    assign b_en_o = b_en;
  end else begin : g_fixed
    logic unused_b;
    assign unused_b = clk_b_i ^ sel_i ^ rst_ni;
    assign clk_o  = clk_a_i;
    assign a_en_o = 1'b1;
    assign b_en_o = 1'b0;
  end

endmodule

// File: rtl/clk_ratio_div.sv
`timescale 1ns/1ps
// Period counter. The field is captured only when a period wraps, so a
// ratio change never truncates or stretches the period in progress.
module clk_ratio_div
  import clk_slice_pkg::*;
#(
  parameter div_mode_e MODE  = DIV_INC_E,
  parameter int        DIV_W = 4,
  parameter int        CNT_W = cnt_width(MODE, DIV_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] field_i,
  output logic             clk_o,
  output logic [DIV_W-1:0] rate_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             wrap_o,
  output logic             phase_o
);

  if (MODE == DIV_NONE_E) begin : g_pass
    logic unused_in;
    assign unused_in = ^field_i ^ rst_ni;
    assign clk_o   = clk_i;
    assign rate_o  = '0;
    assign cnt_o   = '0;
    assign ratio_o = CNT_W'(1);
    assign wrap_o  = 1'b1;
    assign phase_o = 1'b0;
  end else begin : g_count
    logic [DIV_W-1:0] field_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;
    logic             phase_q;
    logic             wrap;
    logic             bypass;

    // Ratio decode from the captured field.
    always_comb begin
      case (MODE)
        DIV_INC_E: ratio = CNT_W'(field_q) + CNT_W'(1);
        DIV_DBL_E: ratio = (CNT_W'(field_q) + CNT_W'(1)) << 1;
        default: begin
          if (32'(field_q) >= 32'(CNT_W - 1)) ratio = CNT_W'(1) << (CNT_W - 1);
          else                                ratio = CNT_W'(2) << field_q;
        end
      endcase
    end

    // High phase gets the extra cycle of an odd ratio.
    assign half   = (ratio >> 1) + {{(CNT_W-1){1'b0}}, ratio[0]};
    assign wrap   = (cnt_q >= ratio - CNT_W'(1));
    assign bypass = (ratio == CNT_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        field_q <= '0;
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (wrap) begin
        field_q <= field_i;
        cnt_q   <= '0;
        phase_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
        phase_q <= (cnt_q + CNT_W'(1)) < half;
      end
    end

    assign clk_o   = bypass ? clk_i : phase_q;
    assign rate_o  = field_q;
    assign cnt_o   = cnt_q;
    assign ratio_o = ratio;
    assign wrap_o  = wrap;
    assign phase_o = phase_q;
  end

endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
// Enable gate. The enable is captured on the falling edge, so it only
// changes while the clock is low and no runt pulse can leave the cell.
module clk_gate_cell #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);

  if (HAS_GATE) begin : g_gate
    logic en_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= en_i;
    end
    assign clk_o = clk_i & en_q;
  end else begin : g_open
    logic unused_en;
    assign unused_en = en_i ^ rst_ni;
    assign clk_o = clk_i;
  end

endmodule

// File: rtl/clk_slice.sv
`timescale 1ns/1ps
module clk_slice
  import clk_slice_pkg::*;
#(
  parameter div_mode_e DIV_MODE = DIV_INC_E,
  parameter int        DIV_W    = 4,
  parameter bit        HAS_MUX  = 1'b1,
  parameter bit        HAS_GATE = 1'b1
) (
  input  logic             clk_base_i,
  input  logic             clk_pll_i,
  input  logic             rst_ni,
  input  logic             gate_en_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_field_i,
  output logic             clk_o,
  output logic [DIV_W-1:0] rate_code_o
);

  localparam int CNT_W = cnt_width(DIV_MODE, DIV_W);

  logic             clk_sel;
  logic             a_en;
  logic             b_en;
  logic             clk_div;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_ratio;
  logic             div_wrap;
  logic             div_phase;

  clk_src_sel #(.HAS_MUX(HAS_MUX)) u_sel (
    .clk_a_i (clk_base_i),
    .clk_b_i (clk_pll_i),
    .rst_ni  (rst_ni),
    .sel_i   (src_sel_i),
    .clk_o   (clk_sel),
    .a_en_o  (a_en),
    .b_en_o  (b_en)
  );

  clk_ratio_div #(.MODE(DIV_MODE), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_div (
    .clk_i   (clk_sel),
    .rst_ni  (rst_ni),
    .field_i (div_field_i),
    .clk_o   (clk_div),
    .rate_o  (rate_code_o),
    .cnt_o   (div_cnt),
    .ratio_o (div_ratio),
    .wrap_o  (div_wrap),
    .phase_o (div_phase)
  );

  clk_gate_cell #(.HAS_GATE(HAS_GATE)) u_gate (
    .clk_i  (clk_div),
    .rst_ni (rst_ni),
    .en_i   (gate_en_i),
    .clk_o  (clk_o)
  );

endmodule

// File: rtl/clk_slice_chk.sv
`timescale 1ns/1ps
module clk_slice_chk #(
  parameter int DIV_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk_div_i,
  input logic             rst_ni,
  input logic             a_en_i,
  input logic             b_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] ratio_i,
  input logic             wrap_i,
  input logic             phase_i,
  input logic [DIV_W-1:0] rate_i
);

  // R7: the two source enables are never on together.
  p_src_excl_r7: assert property (@(posedge clk_div_i) disable iff (!rst_ni)
    !(a_en_i && b_en_i));

  // R1: the period counter stays inside the decoded ratio.
  p_cnt_range_r1: assert property (@(posedge clk_div_i) disable iff (!rst_ni)
    cnt_i < ratio_i);

  // R8: a high phase begins only at a period boundary.
  p_rise_boundary_r8: assert property (@(posedge clk_div_i) disable iff (!rst_ni)
    $rose(phase_i) |-> $past(wrap_i));

  // R8: the readback only moves at a period boundary.
  p_rate_hold_r8: assert property (@(posedge clk_div_i) disable iff (!rst_ni)
    !$past(wrap_i) |-> $stable(rate_i));

endmodule

bind clk_slice clk_slice_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_div_i (clk_sel),
  .rst_ni    (rst_ni),
  .a_en_i    (a_en),
  .b_en_i    (b_en),
  .cnt_i     (div_cnt),
  .ratio_i   (div_ratio),
  .wrap_i    (div_wrap),
  .phase_i   (div_phase),
  .rate_i    (rate_code_o)
);

// File: tb/sim_clk_slice.sv
`timescale 1ns/1ps
module sim_clk_slice;
  import clk_slice_pkg::*;

  localparam real TB = 8.0;  // base source period, 125 MHz
  localparam real TP = 6.0;  // PLL source period

  logic clk_base = 1'b0;
  logic clk_pll  = 1'b0;
  logic rst_n    = 1'b1;
  logic gate_en  = 1'b0;
  logic sel      = 1'b0;
  logic [3:0]  f0 = '0;
  logic [7:0]  f1 = '0;
  logic [2:0]  f2 = '0;
  logic [15:0] f3 = '0;
  logic o0, o1, o2, o3;
  logic [3:0]  r0;
  logic [7:0]  r1;
  logic [2:0]  r2;
  logic [15:0] r3;

  always #(TB/2) clk_base = ~clk_base;
  always #(TP/2) clk_pll  = ~clk_pll;

  clk_slice #(.DIV_MODE(DIV_INC_E), .DIV_W(4), .HAS_MUX(1'b1), .HAS_GATE(1'b1)) u0 (
    .clk_base_i(clk_base), .clk_pll_i(clk_pll), .rst_ni(rst_n), .gate_en_i(gate_en),
    .src_sel_i(sel), .div_field_i(f0), .clk_o(o0), .rate_code_o(r0));
  clk_slice #(.DIV_MODE(DIV_DBL_E), .DIV_W(8), .HAS_MUX(1'b0), .HAS_GATE(1'b1)) u1 (
    .clk_base_i(clk_base), .clk_pll_i(clk_pll), .rst_ni(rst_n), .gate_en_i(gate_en),
    .src_sel_i(sel), .div_field_i(f1), .clk_o(o1), .rate_code_o(r1));
  clk_slice #(.DIV_MODE(DIV_SHIFT_E), .DIV_W(3), .HAS_MUX(1'b1), .HAS_GATE(1'b0)) u2 (
    .clk_base_i(clk_base), .clk_pll_i(clk_pll), .rst_ni(rst_n), .gate_en_i(gate_en),
    .src_sel_i(sel), .div_field_i(f2), .clk_o(o2), .rate_code_o(r2));
  clk_slice #(.DIV_MODE(DIV_NONE_E), .DIV_W(16), .HAS_MUX(1'b0), .HAS_GATE(1'b1)) u3 (
    .clk_base_i(clk_base), .clk_pll_i(clk_pll), .rst_ni(rst_n), .gate_en_i(gate_en),
    .src_sel_i(sel), .div_field_i(f3), .clk_o(o3), .rate_code_o(r3));

  // Edge-timing reference model: last full period and high time per output.
  logic [3:0] outs;
  logic [3:0] prev = '0;
  real rise_t [4];
  real fall_t [4];
  real per_m  [4];
  real hi_m   [4];
  int  edges  [4];
  int  errors = 0;
  int  checks = 0;

  assign outs = {o3, o2, o1, o0};

  initial begin
    for (int k = 0; k < 4; k++) begin
      rise_t[k] = 0.0; fall_t[k] = 0.0; per_m[k] = 0.0; hi_m[k] = 0.0; edges[k] = 0;
    end
  end

  always @(outs) begin
    for (int k = 0; k < 4; k++) begin
      if (outs[k] === 1'b1 && prev[k] !== 1'b1) begin
        per_m[k]  = $realtime - rise_t[k];
        hi_m[k]   = fall_t[k] - rise_t[k];
        rise_t[k] = $realtime;
        edges[k]  = edges[k] + 1;
      end
      if (outs[k] === 1'b0 && prev[k] === 1'b1) fall_t[k] = $realtime;
    end
    prev = outs;
  end

  task automatic chk_real(input real act, input real exp, input string req, input string what);
    checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_int(input longint act, input longint exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int k, input real per, input real hi, input string req, input int n);
    int tgt;
    tgt = edges[k] + n;
    while (edges[k] < tgt) @(posedge clk_base);
    #1;
    chk_real(per_m[k], per, req, $sformatf("u%0d period", k));
    chk_real(hi_m[k],  hi,  req, $sformatf("u%0d high time", k));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_base);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n0, n1, n2, n3;
    #1 rst_n = 1'b0;
    f0 = 4'd3; f1 = 8'd2; f2 = 3'd0; f3 = 16'hABCD; gate_en = 1'b1; sel = 1'b0;
    #39;
    // R9: quiet during reset
    chk_int(outs, 0, "R9", "outputs in reset");
    chk_int(r0, 0, "R9", "u0 rate in reset");
    chk_int(r1, 0, "R9", "u1 rate in reset");
    chk_int(r2, 0, "R9", "u2 rate in reset");
    #22 rst_n = 1'b1;

    measure(0, 4*TB, 2*TB, "R1", 4);
    measure(1, 6*TB, 3*TB, "R2", 3);
    measure(2, 2*TB, 1*TB, "R3", 3);
    measure(3, TB, TB/2, "R4", 3);
    chk_int(r3, 0, "R4", "u3 rate code ignores field");
    chk_int(r0, 3, "R8", "u0 rate code");

    // R5 odd ratio and ratio-1 pass-through
    f0 = 4'd4;
    measure(0, 5*TB, 3*TB, "R5", 3);
    f0 = 4'd0;
    measure(0, TB, TB/2, "R5", 4);
    f0 = 4'd15;
    measure(0, 16*TB, 8*TB, "R1", 3);
    f0 = 4'd3;
    measure(0, 4*TB, 2*TB, "R1", 3);

    // R3 larger shift
    f2 = 3'd3;
    measure(2, 16*TB, 8*TB, "R3", 3);
    f2 = 3'd7;
    measure(2, 256*TB, 128*TB, "R3", 3);
    f2 = 3'd3;
    measure(2, 16*TB, 8*TB, "R3", 3);

    // R4: changing the field of the pass-through slice has no effect
    f3 = 16'h0001;
    measure(3, TB, TB/2, "R4", 3);
    chk_int(r3, 0, "R4", "u3 rate after field write");

    // R8: new field waits for the period boundary
    @(posedge o1);
    #5 f1 = 8'd0;
    idle(2);
    chk_int(r1, 2, "R8", "u1 rate mid-period");
    @(posedge o1);
    #1;
    chk_int(r1, 0, "R8", "u1 rate at boundary");
    chk_real(per_m[1], 6*TB, "R8", "u1 period finished at old ratio");
    measure(1, 2*TB, TB, "R2", 3);
    f1 = 8'd9;
    measure(1, 20*TB, 10*TB, "R2", 3);

    // R6 gating
    gate_en = 1'b0;
    idle(16);
    n0 = edges[0]; n1 = edges[1]; n2 = edges[2]; n3 = edges[3];
    idle(60);
    chk_int(edges[0] - n0, 0, "R6", "u0 edges while gated");
    chk_int(edges[1] - n1, 0, "R6", "u1 edges while gated");
    chk_int(edges[3] - n3, 0, "R6", "u3 edges while gated");
    chk_int(o0, 0, "R6", "u0 level while gated");
    chk_int((edges[2] - n2) > 0 ? 1 : 0, 1, "R6", "ungated u2 keeps running");
    gate_en = 1'b1;
    measure(0, 4*TB, 2*TB, "R6", 2);
    measure(3, TB, TB/2, "R6", 2);

    // R7 source selection
    sel = 1'b1;
    measure(0, 4*TP, 2*TP, "R7", 5);
    measure(2, 16*TP, 8*TP, "R7", 3);
    f0 = 4'd0;
    measure(0, TP, TP/2, "R7", 4);
    f0 = 4'd3;
    sel = 1'b0;
    measure(0, 4*TB, 2*TB, "R7", 5);
    measure(2, 16*TB, 8*TB, "R7", 3);

    summary();
    $finish;
  end

endmodule